// File: doc/BRIEF.md
# Task-State Stack Pointer Fetch Unit

When an interrupt moves execution to a more privileged level, or arrives while the processor runs a virtual-8086 task, the new stack has to come from the current task state segment. This unit takes the target privilege level, the segment's format (16-bit, 32-bit or 64-bit), an optional interrupt-stack slot number, and the segment's base, limit and selector. It works out where the stack fields sit and checks that the last byte it needs lies within the limit. It then reads the fields one byte at a time over a simple request/valid port. It returns the new stack selector and stack pointer, or an invalid-segment fault with its error code.

For the 16-bit and 32-bit formats the fetched selector gets two checks: it must not be null, and its requested privilege field must equal the target level. For the 64-bit format no selector is read. The unit makes a null selector that carries the target level instead. A virtual-8086 entry always targets level 0.

Top module: `tss_stack_fetch`

## Requirements
- R1: 32-bit format (`tss_kind` = 2'b01): with level L, the stack pointer is the 4 bytes at base+8L+4 and the selector is the 2 bytes at base+8L+8. Both are assembled least significant byte first, and `new_sp` is zero-extended.
- R2: 16-bit format (`tss_kind` = 2'b00): with level L, the stack pointer is the 2 bytes at base+4L+2 and the selector is the 2 bytes at base+4L+4. Both are assembled least significant byte first.
- R3: 64-bit format (`tss_kind[1]` = 1): an 8-byte stack pointer is read from base+8L+4 when `ist_index` is 0, and from base+8·`ist_index`+28 otherwise. `new_ss` is {14'b0, L} and no selector check applies.
- R4: With `v86_entry` set, the 16-bit and 32-bit formats use level 0 whatever `target_dpl` holds. In the 64-bit format `v86_entry` has no effect.
- R5: If the offset of the last byte to be read is greater than `tss_limit`, the unit issues no read and signals a fault with code {tss_selector[15:2], 1'b0, ext_event}. A last byte exactly at the limit is accepted.
- R6: A fetched selector with bits [15:2] all zero is null. It faults with code {15'b0, ext_event}, and this check takes precedence over the privilege check.
- R7: A non-null fetched selector whose bits [1:0] differ from the level in use faults with code {sel[15:2], 1'b0, ext_event}.
- R8: Reads go out one byte at a time. `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen, and `rd_req` is low whenever the unit is idle. The byte at each address is read exactly once.
- R9: `busy` rises the cycle after an accepted `start` and stays high until the cycle in which the one-cycle `done` or `fault` pulse appears. In that cycle `busy` is low. The two pulses never coincide, and a `start` seen while busy is ignored rather than queued.
- R10: After reset, `busy`, `done`, `fault` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch; inputs are captured in this cycle |
| tss_kind | input | 2 | Segment format: 00 16-bit, 01 32-bit, 1x 64-bit |
| v86_entry | input | 1 | Entry from virtual-8086 mode (forces level 0) |
| target_dpl | input | 2 | Privilege level being entered |
| ist_index | input | 3 | Interrupt-stack slot, 0 = none (64-bit only) |
| tss_base | input | ADDR_W | Byte address of the segment |
| tss_limit | input | ADDR_W | Highest valid byte offset in the segment |
| tss_selector | input | 16 | Selector of the current segment, for fault codes |
| ext_event | input | 1 | External-event bit copied into fault codes |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse: new stack values valid |
| new_ss | output | 16 | New stack selector |
| new_sp | output | 64 | New stack pointer, zero-extended |
| fault | output | 1 | One-cycle pulse: invalid-segment fault |
| fault_code | output | 16 | Error code of the fault |

## Verification
The bench sweeps every format, level, virtual-8086 setting and interrupt-stack slot, and checks each result against offsets computed in the bench. A unit that used the wrong shift or constant would return the wrong bytes, and one that ignored the slot number would read the level slot. For each format it sets the limit both at the last needed byte and one below it. An off-by-one compare shows up either as a spurious fault or as reads issued past the limit. Null selectors with a matching or non-matching low field, and selectors with the wrong privilege field, expose a wrong order of checks or a wrong error code. Varied read latency, a second `start` sent mid-fetch, and a count of the bytes served catch an address that moves during a wait, a restarted fetch, and extra or missing reads.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int SEL_W   = 16;
    localparam int SP_W    = 64;
    localparam int MAX_RUN = 8;
    localparam int IDX_W   = $clog2(MAX_RUN);
    localparam int OFF_W   = 7;

    typedef enum logic [1:0] {TK_16 = 2'd0, TK_32 = 2'd1, TK_64 = 2'd2} tss_kind_e;

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_READ, ST_FINISH} fsm_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [IDX_W:0]   nbytes;
        logic [IDX_W:0]   spbytes;
        logic [1:0]       lvl;
    } layout_t;

    function automatic tss_kind_e decode_kind(input logic [1:0] m);
        if (m[1]) return TK_64;
        if (m[0]) return TK_32;
        return TK_16;
    endfunction

    function automatic logic [SEL_W-1:0] sel_code(input logic [SEL_W-1:0] sel, input logic ext);
        return {sel[SEL_W-1:2], 1'b0, ext};
    endfunction
endpackage

// File: rtl/tsf_layout.sv
module tsf_layout
    import tsf_pkg::*;
(
    input  tss_kind_e  kind,
    input  logic       v86,
    input  logic [1:0] dpl,
    input  logic [2:0] ist,
    output layout_t    lay
);
    always_comb begin
        lay.lvl = (kind != TK_64 && v86) ? 2'd0 : dpl;
        unique case (kind)
            TK_16: begin
                lay.off     = OFF_W'({lay.lvl, 2'b10});
                lay.nbytes  = (IDX_W+1)'(4);
                lay.spbytes = (IDX_W+1)'(2);
            end
            TK_32: begin
                lay.off     = OFF_W'({lay.lvl, 3'b100});
                lay.nbytes  = (IDX_W+1)'(6);
                lay.spbytes = (IDX_W+1)'(4);
            end
            default: begin
                if (ist != 3'd0)
                    lay.off = OFF_W'({ist, 3'b000}) + OFF_W'(28);
                else
                    lay.off = OFF_W'({lay.lvl, 3'b100});
                lay.nbytes  = (IDX_W+1)'(8);
                lay.spbytes = (IDX_W+1)'(8);
            end
        endcase
    end
endmodule

// File: rtl/tsf_selcheck.sv
module tsf_selcheck
    import tsf_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       lvl,
    input  logic             ext,
    output logic             bad,
    output logic [SEL_W-1:0] code
);
    logic is_null;

    always_comb begin
        is_null = (sel[SEL_W-1:2] == '0);
        bad     = is_null || (sel[1:0] != lvl);
        code    = is_null ? {{(SEL_W-1){1'b0}}, ext} : sel_code(sel, ext);
    end
endmodule

// File: rtl/tss_stack_fetch.sv
module tss_stack_fetch
    import tsf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        tss_kind,
    input  logic              v86_entry,
    input  logic [1:0]        target_dpl,
    input  logic [2:0]        ist_index,
    input  logic [ADDR_W-1:0] tss_base,
    input  logic [ADDR_W-1:0] tss_limit,
    input  logic [15:0]       tss_selector,
    input  logic              ext_event,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [15:0]       new_ss,
    output logic [63:0]       new_sp,
    output logic              fault,
    output logic [15:0]       fault_code
);
    fsm_e              st_q;
    tss_kind_e         kind_q;
    logic              v86_q;
    logic [1:0]        dpl_q;
    logic [2:0]        ist_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [SEL_W-1:0]  sel_q;
    logic              ext_q;
    logic [IDX_W-1:0]  idx_q;

    layout_t           lay;
    logic [ADDR_W-1:0] last_off;
    logic [7:0]        lane_q [MAX_RUN];
    logic [8*MAX_RUN-1:0] gathered;
    logic [SP_W-1:0]   sp_val;
    logic [SEL_W-1:0]  ss_val;
    logic              ss_bad;
    logic [SEL_W-1:0]  ss_code;

    tsf_layout u_layout (
        .kind (kind_q),
        .v86  (v86_q),
        .dpl  (dpl_q),
        .ist  (ist_q),
        .lay  (lay)
    );

    tsf_selcheck u_selcheck (
        .sel  (ss_val),
        .lvl  (lay.lvl),
        .ext  (ext_q),
        .bad  (ss_bad),
        .code (ss_code)
    );

    assign last_off = ADDR_W'(lay.off) + ADDR_W'(lay.nbytes) - ADDR_W'(1);
    assign rd_req   = (st_q == ST_READ);
    assign rd_addr  = base_q + ADDR_W'(lay.off) + ADDR_W'(idx_q);
    assign busy     = (st_q != ST_IDLE);

    for (genvar g = 0; g < MAX_RUN; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else if (st_q == ST_READ && rd_valid && idx_q == IDX_W'(g))
                lane_q[g] <= rd_data;
        end
        assign gathered[8*g +: 8] = lane_q[g];
    end

    always_comb begin
        unique case (kind_q)
            TK_16:   sp_val = SP_W'(gathered[15:0]);
            TK_32:   sp_val = SP_W'(gathered[31:0]);
            default: sp_val = gathered[SP_W-1:0];
        endcase
        ss_val = (kind_q == TK_16) ? gathered[31:16] : gathered[47:32];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            kind_q     <= TK_16;
            v86_q      <= 1'b0;
            dpl_q      <= '0;
            ist_q      <= '0;
            base_q     <= '0;
            limit_q    <= '0;
            sel_q      <= '0;
            ext_q      <= 1'b0;
            idx_q      <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= '0;
            new_ss     <= '0;
            new_sp     <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        kind_q  <= decode_kind(tss_kind);
                        v86_q   <= v86_entry;
                        dpl_q   <= target_dpl;
                        ist_q   <= ist_index;
                        base_q  <= tss_base;
                        limit_q <= tss_limit;
                        sel_q   <= tss_selector;
                        ext_q   <= ext_event;
                        idx_q   <= '0;
                        st_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (last_off > limit_q) begin
                        fault      <= 1'b1;
                        fault_code <= sel_code(sel_q, ext_q);
                        st_q       <= ST_IDLE;
                    end else begin
                        st_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_valid) begin
                        if ({1'b0, idx_q} == lay.nbytes - (IDX_W+1)'(1))
                            st_q <= ST_FINISH;
                        else
                            idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_FINISH: begin
                    st_q <= ST_IDLE;
                    if (kind_q == TK_64) begin
                        done   <= 1'b1;
                        new_ss <= {14'b0, lay.lvl};
                        new_sp <= sp_val;
                    end else if (ss_bad) begin
                        fault      <= 1'b1;
                        fault_code <= ss_code;
                    end else begin
                        done   <= 1'b1;
                        new_ss <= ss_val;
                        new_sp <= sp_val;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr
);
    a_r8_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy);

    a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_fault_single: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    a_r9_start_to_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r9_idle_at_end: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |-> !busy);

    a_r5_no_read_on_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> !rd_req);
endmodule

bind tss_stack_fetch tsf_checker #(.ADDR_W(ADDR_W)) u_tsf_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr)
);

// File: tb/tss_stack_fetch_test.sv
`timescale 1ns/1ps
module tss_stack_fetch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  tss_kind = 2'b00;
    logic        v86_entry = 1'b0;
    logic [1:0]  target_dpl = 2'd0;
    logic [2:0]  ist_index = 3'd0;
    logic [31:0] tss_base = 32'h0;
    logic [31:0] tss_limit = 32'h0;
    logic [15:0] tss_selector = 16'h0;
    logic        ext_event = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        busy, done, fault;
    logic [15:0] new_ss, fault_code;
    logic [63:0] new_sp;

    int checks = 0;
    int failures = 0;

    logic [7:0]  mem [256];
    int          lat = 0;
    int          wait_cnt;
    int          reads;
    int          addr_err;
    logic [31:0] held_addr;

    always #2.5 clk = ~clk;

    tss_stack_fetch uut (
        .clk(clk), .rst(rst), .start(start), .tss_kind(tss_kind),
        .v86_entry(v86_entry), .target_dpl(target_dpl), .ist_index(ist_index),
        .tss_base(tss_base), .tss_limit(tss_limit), .tss_selector(tss_selector),
        .ext_event(ext_event), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .new_ss(new_ss), .new_sp(new_sp), .fault(fault), .fault_code(fault_code)
    );

    // byte memory with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h0;
            wait_cnt <= 0;
            reads    <= 0;
            addr_err <= 0;
            held_addr <= 32'h0;
        end else begin
            rd_valid <= 1'b0;
            if (rd_req && !rd_valid) begin
                if (wait_cnt != 0 && rd_addr != held_addr)
                    addr_err <= addr_err + 1;
                held_addr <= rd_addr;
                if (wait_cnt >= lat) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem[rd_addr[7:0]];
                    wait_cnt <= 0;
                    reads    <= reads + 1;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [1:0] kind, input logic v86, input logic [1:0] dpl,
                            input logic [2:0] ist, input logic [31:0] base,
                            input logic [31:0] limit, input logic ext,
                            input logic [15:0] ss_plant, input int latency,
                            input bit disturb, input string req);
        int lvl, off, n, spb, last, r0, a0;
        bit e_fault, hung, busy_bad;
        logic [15:0] e_code, e_ss;
        logic [63:0] e_sp;
        bit is64;
        is64 = kind[1];
        lvl  = (!is64 && v86) ? 0 : int'(dpl);
        if (is64) begin
            off = (ist != 0) ? int'(ist) * 8 + 28 : lvl * 8 + 4;
            n = 8; spb = 8;
        end else if (kind[0]) begin
            off = lvl * 8 + 4; n = 6; spb = 4;
        end else begin
            off = lvl * 4 + 2; n = 4; spb = 2;
        end
        last = off + n - 1;
        if (!is64) begin
            mem[(int'(base) + off + spb) % 256]     = ss_plant[7:0];
            mem[(int'(base) + off + spb + 1) % 256] = ss_plant[15:8];
        end
        e_sp = 64'h0;
        for (int i = 0; i < spb; i++)
            e_sp = e_sp | (64'(mem[(int'(base) + off + i) % 256]) << (8 * i));
        e_fault = 1'b0; e_code = 16'h0; e_ss = 16'h0;
        if (last > int'(limit)) begin
            e_fault = 1'b1;
            e_code  = {tss_selector[15:2], 1'b0, ext};
        end else if (is64) begin
            e_ss = 16'(lvl);
        end else if (ss_plant[15:2] == 14'h0) begin
            e_fault = 1'b1;
            e_code  = {15'h0, ext};
        end else if (int'(ss_plant[1:0]) != lvl) begin
            e_fault = 1'b1;
            e_code  = {ss_plant[15:2], 1'b0, ext};
        end else begin
            e_ss = ss_plant;
        end

        @(negedge clk);
        lat = latency; r0 = reads; a0 = addr_err;
        tss_kind = kind; v86_entry = v86; target_dpl = dpl; ist_index = ist;
        tss_base = base; tss_limit = limit; ext_event = ext;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hung = 1'b1; busy_bad = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (done || fault) begin hung = 1'b0; break; end
            if (!busy) busy_bad = 1'b1;
            if (disturb && c == 0) begin
                start = 1'b1; target_dpl = ~dpl; tss_kind = ~kind; tss_limit = 32'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(!hung, req, "completion", 64'(hung), 64'h0);
        chk(!busy_bad, "R9", "busy held during fetch", 64'(busy_bad), 64'h0);
        chk(!busy, "R9", "busy low with pulse", 64'(busy), 64'h0);
        chk(fault == e_fault && done == !e_fault, req, "outcome fault", 64'(fault), 64'(e_fault));
        if (e_fault)
            chk(fault_code == e_code, req, "fault code", 64'(fault_code), 64'(e_code));
        else begin
            chk(new_ss == e_ss, req, "new_ss", 64'(new_ss), 64'(e_ss));
            chk(new_sp == e_sp, req, "new_sp", new_sp, e_sp);
        end
        @(negedge clk);
        chk(reads - r0 == ((last > int'(limit)) ? 0 : n), (last > int'(limit)) ? "R5" : "R8",
            "bytes read", 64'(reads - r0), 64'((last > int'(limit)) ? 0 : n));
        chk(addr_err == a0, "R8", "address held while waiting", 64'(addr_err - a0), 64'h0);
        chk(!busy && !done && !fault, "R9", "idle after pulse", 64'({busy, done, fault}), 64'h0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tag;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        tss_selector = 16'h0ABB;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !fault && !rd_req, "R10", "reset outputs",
            64'({busy, done, fault, rd_req}), 64'h0);

        // R1 R2 R3 R4: sweep formats, levels, v86, slots
        for (int k = 0; k < 3; k++)
            for (int v = 0; v < 2; v++)
                for (int d = 0; d < 4; d++)
                    for (int s = 0; s < ((k == 2) ? 8 : 1); s++) begin
                        int lv;
                        lv = (k != 2 && v == 1) ? 0 : d;
                        tag = (k == 0) ? "R2" : (k == 1) ? "R1" : "R3";
                        if (v == 1) tag = "R4";
                        run_case(2'(k), 1'(v), 2'(d), 3'(s), 32'(16 + 48 * ((d + s) % 3)),
                                 32'hFF, 1'((d ^ s) & 1),
                                 {13'(7 + d + 3 * s), 1'b0, 2'(lv)}, (d + s) % 3, 1'b0, tag);
                    end

        // R5 limit boundaries: exactly at last byte passes, one less faults
        for (int k = 0; k < 3; k++)
            for (int d = 0; d < 4; d++) begin
                int lst;
                lst = (k == 0) ? d * 4 + 5 : (k == 1) ? d * 8 + 9 : d * 8 + 11;
                run_case(2'(k), 1'b0, 2'(d), 3'd0, 32'h40, 32'(lst), 1'b1,
                         {13'h11, 1'b0, 2'(d)}, 1, 1'b0, "R5");
                run_case(2'(k), 1'b0, 2'(d), 3'd0, 32'h40, 32'(lst - 1), 1'(d & 1),
                         {13'h11, 1'b0, 2'(d)}, 1, 1'b0, "R5");
            end
        run_case(2'b10, 1'b0, 2'd1, 3'd7, 32'h10, 32'd91, 1'b0, 16'h0, 0, 1'b0, "R5");
        run_case(2'b10, 1'b0, 2'd1, 3'd7, 32'h10, 32'd90, 1'b1, 16'h0, 0, 1'b0, "R5");
        run_case(2'b01, 1'b1, 2'd3, 3'd0, 32'h20, 32'd9, 1'b0, 16'h0048, 0, 1'b0, "R4");
        run_case(2'b01, 1'b1, 2'd3, 3'd0, 32'h20, 32'd8, 1'b1, 16'h0048, 0, 1'b0, "R5");
        run_case(2'b00, 1'b1, 2'd2, 3'd0, 32'h20, 32'd5, 1'b1, 16'h0050, 2, 1'b0, "R4");
        run_case(2'b00, 1'b1, 2'd2, 3'd0, 32'h20, 32'd4, 1'b0, 16'h0050, 2, 1'b0, "R5");

        // R6 null selectors, precedence over level check
        run_case(2'b01, 1'b0, 2'd2, 3'd0, 32'h30, 32'hFF, 1'b1, 16'h0000, 0, 1'b0, "R6");
        run_case(2'b01, 1'b0, 2'd2, 3'd0, 32'h30, 32'hFF, 1'b0, 16'h0002, 1, 1'b0, "R6");
        run_case(2'b00, 1'b0, 2'd1, 3'd0, 32'h30, 32'hFF, 1'b1, 16'h0003, 2, 1'b0, "R6");

        // R7 level mismatch
        run_case(2'b01, 1'b0, 2'd2, 3'd0, 32'h30, 32'hFF, 1'b1, {13'd5, 1'b0, 2'd1}, 0, 1'b0, "R7");
        run_case(2'b00, 1'b0, 2'd0, 3'd0, 32'h50, 32'hFF, 1'b0, {13'd9, 1'b1, 2'd3}, 1, 1'b0, "R7");
        run_case(2'b01, 1'b1, 2'd3, 3'd0, 32'h50, 32'hFF, 1'b1, {13'd9, 1'b0, 2'd3}, 1, 1'b0, "R7");

        // R9 start while busy is ignored
        run_case(2'b10, 1'b0, 2'd2, 3'd3, 32'h60, 32'hFF, 1'b0, 16'h0, 2, 1'b1, "R9");
        run_case(2'b01, 1'b0, 2'd1, 3'd0, 32'h60, 32'hFF, 1'b1, {13'd3, 1'b0, 2'd1}, 1, 1'b1, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule